// File: doc/BRIEF.md
# Signed Word Divider with Overflow Flags

This block is the integer division unit of a processor execute stage. It takes a 32-bit signed dividend and divisor and returns the signed quotient, rounded toward zero. Each operation also carries two control flags. The overflow-enable flag lets the operation raise an overflow indication and feed the sticky summary-overflow bit. The record flag asks for a 4-bit condition field that describes the result.

An operation starts with a one-cycle `start` pulse while `busy` is low. A normal division runs a restoring shift-subtract loop over the operand magnitudes, one quotient bit per cycle, and then applies the sign. Two operand pairs have no defined quotient: any dividend over a zero divisor, and the most negative value over minus one. The block detects both at the input and skips the loop. It completes them on the next cycle with a fixed quotient and a fixed condition encoding. The summary-overflow bit is kept inside the block until the `so_clr` input clears it.

Top module: `sdiv_unit`

## Requirements
- R1: After reset, `busy`, `done`, `ov`, `so`, `quotient` and `cond` are all zero.
- R2: For a divisor that is neither zero nor (with a dividend of 0x80000000) minus one, `quotient` is the signed quotient truncated toward zero.
- R3: A normal division accepted at a clock edge keeps `busy` high for 32 cycles, and its result is presented with a one-cycle `done` pulse in the 33rd cycle after the accepting edge.
- R4: A zero divisor, or a dividend of 0x80000000 with a divisor of 0xFFFFFFFF, completes with `done` in the first cycle after the accepting edge and a `quotient` of 0x80000000.
- R5: `ov` is 1 for an operation only when its overflow-enable flag was set and it was one of the two R4 cases; otherwise it is 0.
- R6: `so` is set by any operation that raises `ov` and stays set until `so_clr` is asserted for a cycle, which clears it.
- R7: `cond` layout is bit 3 = LT, bit 2 = GT, bit 1 = EQ, bit 0 = SO. For a normal division with record set, exactly one of LT, GT and EQ is 1, according to the sign of the quotient compared with zero. With record clear, `cond` is 0000.
- R8: For an R4 case with record set, LT=1, GT=0 and EQ=0, whatever the operands are.
- R9: A `start` pulse while `busy` is high is ignored. The running operation's result and timing are unchanged, and no extra `done` follows.
- R10: The SO bit of a recorded `cond` equals the summary-overflow value after the operation: the prior `so` ORed with this operation's `ov`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation request, taken when `busy` is low |
| dividend | input | 32 | Signed dividend |
| divisor | input | 32 | Signed divisor |
| ov_en | input | 1 | Overflow-enable flag for this operation |
| rec_en | input | 1 | Record flag for this operation |
| so_clr | input | 1 | Clears the summary-overflow bit |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Signed quotient of the last operation |
| ov | output | 1 | Overflow indication of the last operation |
| so | output | 1 | Sticky summary overflow |
| cond | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The assertions assume that `start` is a single-cycle pulse. They also assume that the operands and flags are stable in the accepting cycle. The sticky-bit check assumes that `so_clr` is never raised in the same cycle as a completion that could set the bit. The bench drives every input on the falling edge, holds `start` for exactly one cycle, and pulses `so_clr` only while the unit is idle. The only request made during `busy` is the deliberate one in the R9 test.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    localparam int unsigned DEF_W = 32;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_t;

    typedef enum logic {
        OP_NORMAL = 1'b0,
        OP_FORCED = 1'b1
    } op_kind_e;

    function automatic cond_t make_cond(input logic neg, input logic zero,
                                        input logic forced, input logic so_v);
        cond_t c;
        c.so = so_v;
        if (forced) begin
            c.lt = 1'b1;
            c.gt = 1'b0;
            c.eq = 1'b0;
        end else begin
            c.lt = neg;
            c.eq = zero;
            c.gt = !neg && !zero;
        end
        return c;
    endfunction

endpackage

// File: rtl/sdiv_classify.sv
module sdiv_classify
    import sdiv_pkg::*;
#(
    parameter int unsigned W = DEF_W
) (
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output op_kind_e     kind,
    output logic [W-1:0] num_mag,
    output logic [W-1:0] den_mag,
    output logic         neg
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic den_zero, den_m1, num_min;

    always_comb begin
        den_zero = (den == '0);
        den_m1   = (den == '1);
        num_min  = (num == MOST_NEG);
        kind     = (den_zero || (num_min && den_m1)) ? OP_FORCED : OP_NORMAL;
        num_mag  = num[W-1] ? (~num + 1'b1) : num;
        den_mag  = den[W-1] ? (~den + 1'b1) : den;
        neg      = num[W-1] ^ den[W-1];
    end
endmodule

// File: rtl/sdiv_iter.sv
module sdiv_iter
    import sdiv_pkg::*;
#(
    parameter int unsigned W = DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] num_mag,
    input  logic [W-1:0] den_mag,
    output logic         busy,
    output logic         last,
    output logic [W-1:0] q_next
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    logic [W:0]    rem_q, rem_d;
    logic [W-1:0]  quo_q, quo_d;
    logic [W-1:0]  den_q;
    logic [CW-1:0] cnt_q;

    logic [W:0] shifted, trial;

    always_comb begin
        shifted = {rem_q[W-1:0], quo_q[W-1]};
        trial   = shifted - {1'b0, den_q};
        if (!trial[W]) begin
            rem_d = trial;
            quo_d = {quo_q[W-2:0], 1'b1};
        end else begin
            rem_d = shifted;
            quo_d = {quo_q[W-2:0], 1'b0};
        end
        last   = busy && (cnt_q == LAST_STEP);
        q_next = quo_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            cnt_q <= '0;
            rem_q <= '0;
            quo_q <= num_mag;
            den_q <= den_mag;
        end else if (busy) begin
            rem_q <= rem_d;
            quo_q <= quo_d;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_STEP) begin
                busy <= 1'b0;
            end
        end
    end

    // R3
    load_start_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (busy && cnt_q == '0));

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(cnt_q) == LAST_STEP);
endmodule

// File: rtl/sdiv_result.sv
module sdiv_result
    import sdiv_pkg::*;
#(
    parameter int unsigned W = DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fire_forced,
    input  logic         fire_norm,
    input  logic [W-1:0] q_norm,
    input  logic         ov_en_op,
    input  logic         rec_op,
    input  logic         so_clr,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic         ov,
    output logic         so,
    output cond_t        cond
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic         complete, ov_new, so_base, so_new;
    logic [W-1:0] res;
    cond_t        cond_new;

    always_comb begin
        complete = fire_forced || fire_norm;
        res      = fire_forced ? MOST_NEG : q_norm;
        ov_new   = fire_forced && ov_en_op;
        so_base  = so && !so_clr;
        so_new   = so_base || ov_new;
        cond_new = make_cond(res[W-1], res == '0, fire_forced, so_new);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            quotient <= '0;
            ov       <= 1'b0;
            so       <= 1'b0;
            cond     <= '0;
        end else begin
            done <= complete;
            so   <= complete ? so_new : so_base;
            if (complete) begin
                quotient <= res;
                ov       <= ov_new;
                cond     <= rec_op ? cond_new : '0;
            end
        end
    end

    // R5
    ov_value_chk: assert property (@(posedge clk) disable iff (rst)
        (done && ov) |-> (quotient == MOST_NEG && so));

    // R6
    so_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (so && !so_clr) |=> so);

    // R7
    cond_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (done && cond != '0) |-> ($countones({cond.lt, cond.gt, cond.eq}) == 1));

    // R10
    cond_so_chk: assert property (@(posedge clk) disable iff (rst)
        (done && cond != '0) |-> (cond.so == so));
endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit
    import sdiv_pkg::*;
#(
    parameter int unsigned W = DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    input  logic         ov_en,
    input  logic         rec_en,
    input  logic         so_clr,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic         ov,
    output logic         so,
    output logic [3:0]   cond
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    op_kind_e     kind;
    logic [W-1:0] num_mag, den_mag, q_next, q_signed;
    logic         neg, last, accept, load, fire_forced;
    logic         neg_q, ov_en_q, rec_q;
    cond_t        cond_s;

    sdiv_classify #(.W(W)) u_classify (
        .num     (dividend),
        .den     (divisor),
        .kind    (kind),
        .num_mag (num_mag),
        .den_mag (den_mag),
        .neg     (neg)
    );

    always_comb begin
        accept      = start && !busy;
        fire_forced = accept && (kind == OP_FORCED);
        load        = accept && (kind == OP_NORMAL);
        q_signed    = neg_q ? (~q_next + 1'b1) : q_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            neg_q   <= 1'b0;
            ov_en_q <= 1'b0;
            rec_q   <= 1'b0;
        end else if (load) begin
            neg_q   <= neg;
            ov_en_q <= ov_en;
            rec_q   <= rec_en;
        end
    end

    sdiv_iter #(.W(W)) u_iter (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .num_mag (num_mag),
        .den_mag (den_mag),
        .busy    (busy),
        .last    (last),
        .q_next  (q_next)
    );

    sdiv_result #(.W(W)) u_result (
        .clk         (clk),
        .rst         (rst),
        .fire_forced (fire_forced),
        .fire_norm   (last),
        .q_norm      (q_signed),
        .ov_en_op    (fire_forced ? ov_en : ov_en_q),
        .rec_op      (fire_forced ? rec_en : rec_q),
        .so_clr      (so_clr),
        .done        (done),
        .quotient    (quotient),
        .ov          (ov),
        .so          (so),
        .cond        (cond_s)
    );

    assign cond = cond_s;

    // R4
    forced_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && kind == OP_FORCED) |=> (done && quotient == MOST_NEG));

    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> busy);
endmodule

// File: tb/sdiv_unit_test.sv
module sdiv_unit_test;

    localparam int N = 17;
    localparam logic [31:0] VA [N] = '{
        32'd100, 32'hFFFF_FF9C, 32'd100, 32'hFFFF_FF9C, 32'd0, 32'd7,
        32'hFFFF_FFF9, 32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0000,
        32'h8000_0000, 32'd1, 32'h8000_0000, 32'd5, 32'h8000_0000,
        32'hFFFF_FFFB, 32'h7FFF_FFFF};
    localparam logic [31:0] VB [N] = '{
        32'd7, 32'd7, 32'hFFFF_FFF9, 32'hFFFF_FFF9, 32'd5, 32'd9,
        32'd9, 32'd1, 32'd1, 32'd2,
        32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'd0, 32'hFFFF_FFFF,
        32'd0, 32'hFFFF_FFFF};
    localparam logic [31:0] VQ [N] = '{
        32'd14, 32'hFFFF_FFF2, 32'hFFFF_FFF2, 32'd14, 32'd0, 32'd0,
        32'd0, 32'h7FFF_FFFF, 32'h8000_0000, 32'hC000_0000,
        32'd1, 32'hFFFF_FFFF, 32'h4000_0000, 32'h8000_0000, 32'h8000_0000,
        32'h8000_0000, 32'h8000_0001};
    localparam logic [N-1:0] VOE = 17'b1_1100_1010_1001_0101;
    localparam logic [N-1:0] VREC = 17'b1_0111_1111_1111_1011;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        ov_en = 1'b0;
    logic        rec_en = 1'b0;
    logic        so_clr = 1'b0;
    logic        busy, done, ov, so;
    logic [31:0] quotient;
    logic [3:0]  cond;

    int total = 0;
    int bad = 0;
    logic so_m = 1'b0;

    always #5 clk = ~clk;

    sdiv_unit uut (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend),
        .divisor(divisor), .ov_en(ov_en), .rec_en(rec_en), .so_clr(so_clr),
        .busy(busy), .done(done), .quotient(quotient), .ov(ov), .so(so),
        .cond(cond)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // one operation: returns latency in falling edges after the accepting edge
    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          input logic oe, input logic rec, output int lat);
        @(negedge clk);
        dividend = a; divisor = b; ov_en = oe; rec_en = rec; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic op_and_check(input logic [31:0] a, input logic [31:0] b,
                                input logic [31:0] q_exp, input logic oe,
                                input logic rec);
        int lat;
        logic forced, ov_exp, lt, gt, eq;
        logic [3:0] c_exp;
        forced = (b == 32'd0) || (a == 32'h8000_0000 && b == 32'hFFFF_FFFF);
        ov_exp = forced && oe;
        so_m   = so_m | ov_exp;
        lt = forced ? 1'b1 : q_exp[31];
        eq = forced ? 1'b0 : (q_exp == 32'd0);
        gt = !lt && !eq;
        c_exp = rec ? {lt, gt, eq, so_m} : 4'b0000;
        run_op(a, b, oe, rec, lat);
        check(forced ? "R4 latency" : "R3 latency", lat, forced ? 1 : 33);
        check(forced ? "R4 quotient" : "R2 quotient", quotient, q_exp);
        check("R5 ov", {31'd0, ov}, {31'd0, ov_exp});
        check("R6 so", {31'd0, so}, {31'd0, so_m});
        check(forced && rec ? "R8 cond" : "R7 R10 cond", {28'd0, cond}, {28'd0, c_exp});
        @(negedge clk);
        check("R3 done one cycle", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 reset busy", {31'd0, busy}, 32'd0);
        check("R1 reset done", {31'd0, done}, 32'd0);
        check("R1 reset quotient", quotient, 32'd0);
        check("R1 reset flags", {29'd0, ov, so, |cond}, 32'd0);

        for (int i = 0; i < N; i++) begin
            op_and_check(VA[i], VB[i], VQ[i], VOE[i], VREC[i]);
        end

        // R6 clear of the sticky bit
        check("R6 so set before clear", {31'd0, so}, 32'd1);
        @(negedge clk);
        so_clr = 1'b1;
        @(negedge clk);
        so_clr = 1'b0;
        so_m = 1'b0;
        check("R6 so cleared", {31'd0, so}, 32'd0);

        // R10 recorded SO follows the cleared bit; R8 forced without overflow
        op_and_check(32'd9, 32'hFFFF_FFFD, 32'hFFFF_FFFD, 1'b1, 1'b1);
        op_and_check(32'd0, 32'd0, 32'h8000_0000, 1'b0, 1'b1);
        op_and_check(32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 1'b1, 1'b1);

        // R9 start while busy is ignored
        begin
            int lat;
            int extra;
            @(negedge clk);
            dividend = 32'd1000; divisor = 32'd10; ov_en = 1'b0; rec_en = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (4) @(negedge clk);
            dividend = 32'd5; divisor = 32'd0; ov_en = 1'b1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            lat = 6;
            while (!done && lat < 100) begin
                @(negedge clk);
                lat++;
            end
            check("R9 latency unchanged", lat, 33);
            check("R9 quotient of first op", quotient, 32'd100);
            check("R9 no overflow", {31'd0, ov}, 32'd0);
            extra = 0;
            repeat (4) begin
                @(negedge clk);
                if (done) extra++;
            end
            check("R9 no extra done", extra, 0);
        end

        finish_run();
    end

endmodule